// File: doc/BRIEF.md
# Paced Dedicated Copy Channel

This block is one channel of a copy engine for peripherals that move data in bursts. Software fills in a source start address, a destination start address, a byte count and a pacing word, then sets the start bit. The channel reads one byte from the source and writes it to the destination, and repeats this until the count is used up. Each side can either step its address by one per byte or hold it fixed, which suits a peripheral data port.

The pacing word splits the traffic on each side into blocks. After a block, that side stays quiet for a set number of cycles. A hardware busy flag is reported next to the software start bit. The channel pulses a half-way event and an end event. A continuous mode restarts the same copy without end. Clearing the start bit stops the channel after the byte it is moving at that time.

Reads use a request channel with valid/ready and a response strobe. Writes use a valid/ready channel. Once a request valid is raised, it and its address (and its data, for writes) hold until ready is seen. Ready may stay low for any number of cycles, and that pauses the channel. Only one read is outstanding at a time. A response strobe that arrives when no read is waiting is ignored. The register port is plain: a write strobe, and a read port that returns data in the same cycle. Channel base decoding is done outside the block.

Top module: `dd_chan`

## Requirements
- R1: After reset every register reads 0, and rd_req_valid, wr_valid, evt_half and evt_end are all 0.
- R2: The registers sit at these offsets: control 0x00, source start 0x04, destination start 0x08, count 0x0C and pacing 0x18. Source, destination and pacing read back all 32 bits. Count keeps bits 13:0 only. Control bits 29:0 read back as written, except bit 30.
- R3: Control bit 31 is start and bit 30 is busy. Setting start while the channel is idle begins a copy of a non-zero count. Busy reads 1 from the second rising edge after the write until the final write handshake. Reads are issued one byte at a time.
- R4: Control bits 6:5 set the source address mode and bits 22:21 set the destination mode. Mode 1 holds the address fixed at its start value. Modes 0, 2 and 3 step the address by one per byte.
- R5: Exactly count writes occur. Write number i carries the byte returned by read number i.
- R6: The pacing word holds destination block size in bits 31:24, destination wait in 23:16, source block size in 15:8 and source wait in 7:0. A block size of 0 counts as 1. After each block of B handshakes on a side, that side's valid stays low for at least W cycles.
- R7: The end event pulses for one cycle, in the cycle after the final write handshake. In that same cycle busy reads 0 and start reads 0.
- R8: For a count of 2 or more, the half event pulses once per pass, in the cycle after the write handshake that brings the written count to count/2 (rounded down). It never pulses together with the end event.
- R9: When control bit 29 (continuous) is set, start and busy stay 1 at the end of a pass. The copy then restarts from both start addresses, and the end event pulses once per pass.
- R10: Clearing start while busy issues no new read. The byte in flight is still written, busy then drops, and the end event does not pulse.
- R11: Starting with a count of 0 makes no access. The end event pulses one rising edge after the write that set start, and start then reads 0.
- R12: While busy, a write of start = 1 does not restart the copy. Writes to the address and count registers only affect the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| rd_req_valid | output | 1 | Source read request valid |
| rd_req_ready | input | 1 | Source read request accepted |
| rd_req_addr | output | 32 | Source read address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 8 | Read data |
| wr_valid | output | 1 | Destination write valid |
| wr_ready | input | 1 | Destination write accepted |
| wr_addr | output | 32 | Destination write address |
| wr_data | output | 8 | Destination write data |
| evt_half | output | 1 | Half-way event pulse |
| evt_end | output | 1 | End event pulse |

## Verification
The bench drives inputs just after the rising edge and samples on the falling edge. A handshake is judged at the falling edge before the rising edge that completes it. The end and half events, and busy falling, are then expected at the very next falling edge. Busy is read 2 cycles after the start write is driven, that is, just after the second rising edge. The zero-count end pulse is expected one rising edge after the start write is captured. Pacing gaps are counted as falling edges with valid low after a block's last handshake, and the count must reach the programmed wait.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int REG_W   = 32;
  localparam int OFS_W   = 5;
  localparam int PACE_W  = 8;
  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [OFS_W-1:0] OFS_SRC  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DST  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PACE = 5'h18;
  localparam int BIT_START = 31;
  localparam int BIT_BUSY  = 30;
  localparam int BIT_CONT  = 29;

  typedef enum logic [1:0] {
    AM_STEP  = 2'd0,
    AM_HOLD  = 2'd1,
    AM_PAGEH = 2'd2,
    AM_PAGEV = 2'd3
  } amode_t;

  typedef struct packed {
    logic [PACE_W-1:0] dblk;
    logic [PACE_W-1:0] dgap;
    logic [PACE_W-1:0] sblk;
    logic [PACE_W-1:0] sgap;
  } pace_t;

  // page modes are handled as plain stepping
  function automatic logic mode_steps(input logic [1:0] m);
    return m != AM_HOLD;
  endfunction
endpackage

// File: rtl/dd_regs.sv
module dd_regs
  import dd_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  output logic              start_o,
  output logic              go_o,
  output logic [REG_W-1:0]  src_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output pace_t             pace_o,
  output logic              cont_o,
  output logic [1:0]        smode_o,
  output logic [1:0]        dmode_o
);
  localparam int CTL_W = BIT_BUSY;

  logic [CTL_W-1:0] ctl_q;
  logic             start_q, go_q;
  logic [REG_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  pace_t            pace_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      start_q <= 1'b0;
      go_q    <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      pace_q  <= '0;
    end else begin
      go_q <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          OFS_CTRL: begin
            ctl_q <= wdata_i[CTL_W-1:0];
            if (busy_i) begin
              start_q <= start_q & wdata_i[BIT_START];
            end else begin
              start_q <= wdata_i[BIT_START];
              go_q    <= wdata_i[BIT_START] & ~start_q;
            end
          end
          OFS_SRC:  src_q  <= wdata_i;
          OFS_DST:  dst_q  <= wdata_i;
          OFS_CNT:  cnt_q  <= wdata_i[CNT_W-1:0];
          OFS_PACE: pace_q <= wdata_i;
          default: ;
        endcase
      end
      if (fin_i) start_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = {start_q, busy_i, ctl_q};
      OFS_SRC:  rdata_o = src_q;
      OFS_DST:  rdata_o = dst_q;
      OFS_CNT:  rdata_o = {{(REG_W-CNT_W){1'b0}}, cnt_q};
      OFS_PACE: rdata_o = pace_q;
      default:  rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign go_o    = go_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign pace_o  = pace_q;
  assign cont_o  = ctl_q[BIT_CONT];
  assign smode_o = ctl_q[6:5];
  assign dmode_o = ctl_q[22:21];

  // start may only be raised while the channel is idle
  p_start_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(!busy_i));
  // a launch pulse never comes while busy
  p_go_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !busy_i);
endmodule

// File: rtl/dd_pacer.sv
module dd_pacer
  import dd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              hs_i,
  input  logic [PACE_W-1:0] blk_i,
  input  logic [PACE_W-1:0] gap_i,
  output logic              ok_o
);
  logic [PACE_W-1:0] beat_q, gap_q, blk_eff;
  logic              blk_last;

  assign blk_eff  = (blk_i == '0) ? PACE_W'(1) : blk_i;
  assign blk_last = ({1'b0, beat_q} + 1'b1) >= {1'b0, blk_eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      gap_q  <= '0;
    end else if (clr_i) begin
      beat_q <= '0;
      gap_q  <= '0;
    end else if (hs_i) begin
      if (blk_last) begin
        beat_q <= '0;
        gap_q  <= gap_i;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign ok_o = (gap_q == '0);

  // closing a block with a non-zero wait blocks the side next cycle
  p_gap_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_i && !clr_i && blk_last && gap_i != '0) |=> !ok_o);
  // no handshake may happen while the side is waiting
  p_no_hs_in_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_i |-> ok_o);
endmodule

// File: rtl/dd_engine.sv
module dd_engine
  import dd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              start_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  pace_t             pace_i,
  input  logic              cont_i,
  input  logic [1:0]        smode_i,
  input  logic [1:0]        dmode_i,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [REG_W-1:0]  rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DW-1:0]     rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              busy_o,
  output logic              fin_o,
  output logic              evt_half,
  output logic              evt_end
);
  localparam int NSIDE = 2;

  logic             busy_q, rq_q, pend_q, full_q, half_q, end_q;
  logic             cont_l, s_step, d_step;
  logic [REG_W-1:0] s_base, d_base, s_ptr, d_ptr;
  logic [CNT_W-1:0] tot, rd_cnt, wr_cnt;
  logic [DW-1:0]    buf_q;
  pace_t            pace_l;

  logic             rd_hs, wr_hs, inflight, can_issue, last_wr, drain_done;
  logic [NSIDE-1:0] side_hs, side_ok;
  logic [PACE_W-1:0] side_blk [NSIDE];
  logic [PACE_W-1:0] side_gap [NSIDE];

  assign side_hs     = {wr_hs, rd_hs};
  assign side_blk[0] = pace_l.sblk;
  assign side_gap[0] = pace_l.sgap;
  assign side_blk[1] = pace_l.dblk;
  assign side_gap[1] = pace_l.dgap;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dd_pacer u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (go_i),
      .hs_i  (side_hs[g]),
      .blk_i (side_blk[g]),
      .gap_i (side_gap[g]),
      .ok_o  (side_ok[g])
    );
  end

  assign rd_hs      = rq_q & rd_req_ready;
  assign wr_valid   = full_q & side_ok[1];
  assign wr_hs      = wr_valid & wr_ready;
  assign inflight   = rq_q | pend_q | full_q;
  assign can_issue  = busy_q & start_i & ~inflight & (rd_cnt < tot) & side_ok[0];
  assign last_wr    = wr_hs & (({1'b0, wr_cnt} + 1'b1) == {1'b0, tot});
  assign drain_done = busy_q & ~start_i & ~inflight;
  assign fin_o      = (busy_q & last_wr & start_i & ~cont_l) | (go_i & (cnt_i == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rq_q <= 1'b0; pend_q <= 1'b0; full_q <= 1'b0;
      half_q <= 1'b0; end_q <= 1'b0; cont_l <= 1'b0;
      s_step <= 1'b0; d_step <= 1'b0;
      s_base <= '0; d_base <= '0; s_ptr <= '0; d_ptr <= '0;
      tot <= '0; rd_cnt <= '0; wr_cnt <= '0; buf_q <= '0; pace_l <= '0;
    end else begin
      half_q <= 1'b0;
      end_q  <= 1'b0;
      if (go_i) begin
        pace_l <= pace_i;
        cont_l <= cont_i;
        s_step <= mode_steps(smode_i);
        d_step <= mode_steps(dmode_i);
        s_base <= src_i;  s_ptr <= src_i;
        d_base <= dst_i;  d_ptr <= dst_i;
        tot    <= cnt_i;
        rd_cnt <= '0;
        wr_cnt <= '0;
        if (cnt_i == '0) end_q  <= 1'b1;
        else             busy_q <= 1'b1;
      end else begin
        if (rd_hs) begin
          rq_q   <= 1'b0;
          pend_q <= 1'b1;
          rd_cnt <= rd_cnt + 1'b1;
          if (s_step) s_ptr <= s_ptr + 1'b1;
        end else if (can_issue) begin
          rq_q <= 1'b1;
        end
        if (rd_rsp_valid && pend_q) begin
          pend_q <= 1'b0;
          full_q <= 1'b1;
          buf_q  <= rd_rsp_data;
        end
        if (wr_hs) begin
          full_q <= 1'b0;
          wr_cnt <= wr_cnt + 1'b1;
          if (d_step) d_ptr <= d_ptr + 1'b1;
          if (tot >= CNT_W'(2) && ({1'b0, wr_cnt} + 1'b1) == {1'b0, tot >> 1})
            half_q <= 1'b1;
        end
        if (last_wr) begin
          if (start_i) begin
            end_q <= 1'b1;
            if (cont_l) begin
              rd_cnt <= '0;
              wr_cnt <= '0;
              s_ptr  <= s_base;
              d_ptr  <= d_base;
            end else begin
              busy_q <= 1'b0;
            end
          end else begin
            busy_q <= 1'b0;
          end
        end else if (drain_done) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign rd_req_valid = rq_q;
  assign rd_req_addr  = s_ptr;
  assign wr_addr      = d_ptr;
  assign wr_data      = buf_q;
  assign busy_o       = busy_q;
  assign evt_half     = half_q;
  assign evt_end      = end_q;

  // read request and address hold until accepted
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // write request, address and data hold until accepted
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  // at most one byte is on its way through the channel
  p_one_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rq_q, pend_q, full_q}));
  // a new read only follows a cycle where the source side was not waiting
  p_src_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(side_ok[0]));
  // no read starts once start has been cleared
  p_no_read_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> $past(start_i));
  // end follows a final write or a zero-count launch
  p_end_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |-> ($past(wr_valid && wr_ready) || $past(go_i)));
  // half and end never share a cycle
  p_half_not_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_half && evt_end));
  // an idle channel makes no requests
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!rd_req_valid && !wr_valid));
endmodule

// File: rtl/dd_chan.sv
module dd_chan
  import dd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFS_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [REG_W-1:0]  rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DW-1:0]     rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              evt_half,
  output logic              evt_end
);
  logic             busy, fin, start, go, cont;
  logic [REG_W-1:0] src, dst;
  logic [CNT_W-1:0] cnt;
  pace_t            pace;
  logic [1:0]       smode, dmode;

  dd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .busy_i  (busy),
    .fin_i   (fin),
    .start_o (start),
    .go_o    (go),
    .src_o   (src),
    .dst_o   (dst),
    .cnt_o   (cnt),
    .pace_o  (pace),
    .cont_o  (cont),
    .smode_o (smode),
    .dmode_o (dmode)
  );

  dd_engine #(.DW(DW), .CNT_W(CNT_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .start_i      (start),
    .src_i        (src),
    .dst_i        (dst),
    .cnt_i        (cnt),
    .pace_i       (pace),
    .cont_i       (cont),
    .smode_i      (smode),
    .dmode_i      (dmode),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .busy_o       (busy),
    .fin_o        (fin),
    .evt_half     (evt_half),
    .evt_end      (evt_end)
  );
endmodule

// File: tb/sim_dd_chan.sv
module sim_dd_chan;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = 5'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = 8'h0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        evt_half, evt_end;

  dd_chan u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  // expected configuration
  logic [31:0] e_src, e_dst;
  int e_cnt, e_sblk, e_swt, e_dblk, e_dwt;
  bit e_sfix, e_dfix, e_cont, e_abort;

  // monitor state
  int rd_i, wr_i, rd_total, wr_total, end_cnt, half_cnt, lat;
  logic [31:0] rsp_addr;
  bit exp_end, exp_half;
  int r_beats, r_idle, w_beats, w_idle;
  bit r_flag, w_flag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input bit fix, input int i);
    return fix ? b : b + 32'(i);
  endfunction

  function automatic int blk_eff(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // memory model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_end) begin
        chk(evt_end === 1'b1, "R7 end pulse", 32'(evt_end), 1);
        if (!e_cont && cfg_addr == 5'h0)
          chk(cfg_rdata[31:30] == 2'b00, "R7 busy/start low at end", 32'(cfg_rdata[31:30]), 0);
        exp_end = 0;
      end
      if (exp_half) begin
        chk(evt_half === 1'b1, "R8 half pulse", 32'(evt_half), 1);
        exp_half = 0;
      end
      if (evt_end) end_cnt++;
      if (evt_half) half_cnt++;

      rd_rsp_valid = 1'b0;
      if (lat > 0) lat--;
      else if (lat == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem_byte(rsp_addr);
        lat = -1;
      end

      // pacing: idle samples after a block
      if (rd_req_valid && r_flag) begin
        chk(r_idle >= e_swt, "R6 source wait", 32'(r_idle), 32'(e_swt));
        r_flag = 0;
      end else if (!rd_req_valid && r_flag) r_idle++;
      if (wr_valid && w_flag) begin
        chk(w_idle >= e_dwt, "R6 destination wait", 32'(w_idle), 32'(e_dwt));
        w_flag = 0;
      end else if (!wr_valid && w_flag) w_idle++;

      rd_req_ready = ($urandom % 4) != 0;
      if (rd_req_valid && rd_req_ready) begin
        chk(rd_req_addr == exp_addr(e_src, e_sfix, rd_i), "R4 read address",
            rd_req_addr, exp_addr(e_src, e_sfix, rd_i));
        rsp_addr = rd_req_addr;
        lat = int'($urandom % 3);
        rd_total++;
        rd_i++;
        if (e_cont && rd_i == e_cnt) rd_i = 0;
        r_beats++;
        if (r_beats == blk_eff(e_sblk)) begin r_beats = 0; r_flag = 1; r_idle = 0; end
      end

      wr_ready = ($urandom % 3) != 0;
      if (wr_valid && wr_ready) begin
        chk(wr_addr == exp_addr(e_dst, e_dfix, wr_i), "R4 write address",
            wr_addr, exp_addr(e_dst, e_dfix, wr_i));
        chk(wr_data == mem_byte(exp_addr(e_src, e_sfix, wr_i)), "R5 write data",
            32'(wr_data), 32'(mem_byte(exp_addr(e_src, e_sfix, wr_i))));
        wr_total++;
        wr_i++;
        if (e_cnt >= 2 && wr_i == e_cnt / 2) exp_half = 1;
        if (wr_i == e_cnt) begin
          if (!e_abort) exp_end = 1;
          if (e_cont) wr_i = 0;
        end
        w_beats++;
        if (w_beats == blk_eff(e_dblk)) begin w_beats = 0; w_flag = 1; w_idle = 0; end
      end
    end
  end

  task automatic wcfg(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0; cfg_addr = 5'h0;
  endtask

  task automatic rcfg(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    cfg_addr = a; #1;
    d = cfg_rdata;
    cfg_addr = 5'h0;
  endtask

  task automatic prog(input logic [31:0] s, d, input int n, input logic [1:0] sm, dm,
                      input int sb, sw, db, dw, input bit cont);
    e_src = s; e_dst = d; e_cnt = n; e_sfix = (sm == 2'd1); e_dfix = (dm == 2'd1);
    e_sblk = sb; e_swt = sw; e_dblk = db; e_dwt = dw; e_cont = cont; e_abort = 0;
    rd_i = 0; wr_i = 0; rd_total = 0; wr_total = 0; end_cnt = 0; half_cnt = 0;
    r_beats = 0; r_flag = 0; w_beats = 0; w_flag = 0;
    wcfg(5'h04, s);
    wcfg(5'h08, d);
    wcfg(5'h0C, 32'(n));
    wcfg(5'h18, {8'(db), 8'(dw), 8'(sb), 8'(sw)});
  endtask

  function automatic logic [31:0] ctl_word(input bit st, input logic [1:0] sm, dm, input bit cont);
    return (32'(st) << 31) | (32'(cont) << 29) | (32'(dm) << 21) | (32'(sm) << 5);
  endfunction

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (cfg_rdata[31:30] == 2'b00) break;
    end
  endtask

  task automatic run_xfer(input logic [31:0] s, d, input int n, input logic [1:0] sm, dm,
                          input int sb, sw, db, dw);
    prog(s, d, n, sm, dm, sb, sw, db, dw, 0);
    wcfg(5'h00, ctl_word(1, sm, dm, 0));
    chk(cfg_rdata[30] == 1'b0, "R3 busy low right after start write", 32'(cfg_rdata[30]), 0);
    @(posedge clk); #2;
    chk(cfg_rdata[30] == 1'b1, "R3 busy high second edge", 32'(cfg_rdata[30]), 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(wr_total == n, "R5 write count", 32'(wr_total), 32'(n));
    chk(rd_total == n, "R3 read count", 32'(rd_total), 32'(n));
    chk(end_cnt == 1, "R7 one end pulse", 32'(end_cnt), 1);
    chk(half_cnt == ((n >= 2) ? 1 : 0), "R8 half pulse count", 32'(half_cnt), (n >= 2) ? 1 : 0);
  endtask

  initial begin
    logic [31:0] v;
    int base_wr;
    void'($urandom(32'h5eed));
    lat = -1; exp_end = 0; exp_half = 0;
    e_src = 0; e_dst = 0; e_cnt = 0; e_sfix = 0; e_dfix = 0; e_cont = 0; e_abort = 0;
    e_sblk = 0; e_swt = 0; e_dblk = 0; e_dwt = 0;
    rd_i = 0; wr_i = 0; rd_total = 0; wr_total = 0; end_cnt = 0; half_cnt = 0;
    r_beats = 0; r_idle = 0; w_beats = 0; w_idle = 0; r_flag = 0; w_flag = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    foreach (v[i]) begin end
    for (int k = 0; k < 5; k++) begin
      logic [4:0] a;
      a = (k == 4) ? 5'h18 : 5'(k * 4);
      rcfg(a, v);
      chk(v == 32'h0, "R1 register reset", v, 0);
    end
    chk({rd_req_valid, wr_valid, evt_half, evt_end} == 4'b0, "R1 outputs idle",
        32'({rd_req_valid, wr_valid, evt_half, evt_end}), 0);

    // R2 readback
    wcfg(5'h04, 32'hDEAD_BEEF); rcfg(5'h04, v); chk(v == 32'hDEAD_BEEF, "R2 source", v, 32'hDEAD_BEEF);
    wcfg(5'h08, 32'h1234_5678); rcfg(5'h08, v); chk(v == 32'h1234_5678, "R2 destination", v, 32'h1234_5678);
    wcfg(5'h0C, 32'hFFFF_FFFF); rcfg(5'h0C, v); chk(v == 32'h0000_3FFF, "R2 count width", v, 32'h3FFF);
    wcfg(5'h18, 32'hA5C3_0F81); rcfg(5'h18, v); chk(v == 32'hA5C3_0F81, "R2 pacing", v, 32'hA5C3_0F81);
    wcfg(5'h00, 32'h7FFF_FFFF); rcfg(5'h00, v); chk(v == 32'h3FFF_FFFF, "R2 control", v, 32'h3FFF_FFFF);
    wcfg(5'h00, 32'h0);

    // R11 zero count
    prog(32'h100, 32'h200, 0, 2'd0, 2'd0, 1, 0, 1, 0, 0);
    wcfg(5'h00, ctl_word(1, 0, 0, 0));
    chk(evt_end == 1'b0, "R11 no end yet", 32'(evt_end), 0);
    @(posedge clk); #2;
    chk(evt_end == 1'b1, "R11 end pulse", 32'(evt_end), 1);
    chk(cfg_rdata[31:30] == 2'b00, "R11 start cleared", 32'(cfg_rdata[31:30]), 0);
    repeat (10) @(negedge clk);
    chk(rd_total == 0 && wr_total == 0, "R11 no access", 32'(rd_total + wr_total), 0);

    // directed: both sides stepping, both fixed, mixed page modes
    run_xfer(32'h0000_1000, 32'h0000_8000, 8, 2'd0, 2'd0, 0, 0, 0, 0);
    run_xfer(32'h0000_40F0, 32'h0000_9000, 5, 2'd1, 2'd1, 2, 3, 1, 2);
    run_xfer(32'h0000_20FE, 32'h0000_A0FE, 7, 2'd2, 2'd3, 3, 4, 2, 5);
    run_xfer(32'h0000_3000, 32'h0000_B000, 1, 2'd0, 2'd1, 1, 1, 1, 1);
    run_xfer(32'h0000_5000, 32'h0000_C000, 2, 2'd1, 2'd0, 0, 6, 0, 6);

    // random
    for (int t = 0; t < 10; t++) begin
      run_xfer($urandom, $urandom, 1 + int'($urandom % 12), 2'($urandom), 2'($urandom),
               int'($urandom % 4), int'($urandom % 5), int'($urandom % 4), int'($urandom % 5));
    end

    // R12 writes during a copy
    prog(32'h0000_6000, 32'h0000_D000, 10, 2'd0, 2'd0, 2, 1, 2, 1, 0);
    wcfg(5'h00, ctl_word(1, 0, 0, 0));
    for (int k = 0; k < 5000 && wr_total < 3; k++) @(negedge clk);
    wcfg(5'h04, 32'h0000_7777);
    wcfg(5'h0C, 32'd2);
    wcfg(5'h00, ctl_word(1, 0, 0, 0));
    wait_idle();
    repeat (3) @(negedge clk);
    chk(wr_total == 10, "R12 copy unaffected", 32'(wr_total), 10);
    chk(end_cnt == 1, "R12 no restart", 32'(end_cnt), 1);
    rcfg(5'h04, v);
    chk(v == 32'h0000_7777, "R12 new source kept for next", v, 32'h7777);

    // R10 abort mid copy
    prog(32'h0000_1100, 32'h0000_E000, 24, 2'd0, 2'd0, 1, 0, 1, 0, 0);
    wcfg(5'h00, ctl_word(1, 0, 0, 0));
    for (int k = 0; k < 5000 && wr_total < 5; k++) @(negedge clk);
    wcfg(5'h00, ctl_word(0, 0, 0, 0));
    e_abort = 1;
    wait_idle();
    base_wr = wr_total;
    repeat (20) @(negedge clk);
    chk(end_cnt == 0, "R10 no end pulse", 32'(end_cnt), 0);
    chk(rd_total == wr_total, "R10 in-flight byte written", 32'(wr_total), 32'(rd_total));
    chk(wr_total < 24 && wr_total == base_wr, "R10 stopped", 32'(wr_total), 32'(base_wr));

    // R9 continuous
    prog(32'h0000_2200, 32'h0000_F000, 3, 2'd0, 2'd0, 1, 1, 1, 1, 1);
    wcfg(5'h00, ctl_word(1, 0, 0, 1));
    for (int k = 0; k < 10000 && end_cnt < 2; k++) @(negedge clk);
    chk(end_cnt == 2, "R9 end each pass", 32'(end_cnt), 2);
    chk(cfg_rdata[31:30] == 2'b11, "R9 start and busy kept", 32'(cfg_rdata[31:30]), 3);
    chk(wr_total >= 6, "R9 repeats", 32'(wr_total), 6);
    wcfg(5'h00, ctl_word(0, 0, 0, 1));
    e_abort = 1;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(cfg_rdata[31:30] == 2'b00, "R9 stops after clear", 32'(cfg_rdata[31:30]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule